// File: doc/BRIEF.md
# Supply Switchover Controller

This block decides whether the chip runs from its main supply or from its backup cell. It does not measure voltages. Four analog comparators outside the block report where the main rail sits against the backup voltage and against a fixed trip level, each with its own hysteresis. The block passes these flags through a synchronizer. It then requires every change of state to be backed by a condition that holds for a set number of consecutive clocks. A low-power control bit takes the trip comparison out of the decision, and the block reports that the trip monitor may be powered down.

The controller also handles battery sealing. After power comes up from nothing, the battery stays disconnected until the main rail has been qualified good once. A reseal request issued while running from main arms a return to that sealed condition, and the controller falls back into it on the next loss of main. A sticky flag records that the logic came out of a total power loss, and a clear pulse drops it.

Four named states make up the controller:
- SEALED: the battery is disconnected and main is selected.
- MAIN: running from main, with the battery connected and ready.
- BACKUP: running from the battery, with the serial bus disabled.
- ARMED: a reseal is pending, the battery is disconnected and main is selected.

The transitions are:
- seal-release: SEALED to MAIN.
- drop: MAIN to BACKUP.
- recover: BACKUP to MAIN.
- reseal: MAIN to ARMED.
- arm-loss: ARMED to SEALED.

Top module: `supply_switch_ctrl`

## Requirements
- R1: After the asynchronous active-low reset the state is SEALED. The outputs are then sel_backup=0, bus_disable=0, bat_connect=0 and pwr_fail=1, and trip_mon_en equals the inverse of lp_mode.
- R2: While SEALED, the battery is never connected and backup is never selected, whatever the comparator inputs do.
- R3: Seal-release happens once main is good. Main is good when main_gt_bkp_hi=1 or main_gt_trip_hi=1; in low-power mode only main_gt_bkp_hi counts. After seal-release, bat_connect=1.
- R4: In normal mode (lp_mode=0), drop requires main_lt_bkp_lo=1 and main_lt_trip=1 together. Either flag alone never selects backup.
- R5: In normal mode, recover happens when main_gt_bkp_hi=1 or main_gt_trip_hi=1, either alone being enough.
- R6: A comparator condition reaches the decision through SYNC_STAGES flops. A transition then needs the condition true on DWELL consecutive clocks. The outputs change SYNC_STAGES+DWELL rising edges after the first edge that samples the new input. A condition that holds for fewer than DWELL clocks causes no transition.
- R7: With lp_mode=1, both trip comparators are ignored. Drop needs only main_lt_bkp_lo=1, recover needs only main_gt_bkp_hi=1, and trip_mon_en=0.
- R8: In BACKUP, sel_backup=1, bus_disable=1 and bat_connect=1. In every other state, sel_backup=0 and bus_disable=0.
- R9: A reseal_req high in MAIN takes effect at the next rising edge, giving bat_connect=0. The reseal wins over a drop qualified in the same cycle. In BACKUP or SEALED the request is ignored.
- R10: While ARMED, backup is never selected and the battery stays disconnected, even with main held good. A qualified main loss (the drop condition) moves to SEALED, and a later qualified good main releases the seal again.
- R11: pwr_fail is set only by reset. A one-cycle pwr_fail_clr pulse clears it, and it then stays low until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, asserted on total power loss |
| main_lt_bkp_lo | input | 1 | Comparator: main below backup minus hysteresis |
| main_gt_bkp_hi | input | 1 | Comparator: main above backup plus hysteresis |
| main_lt_trip | input | 1 | Comparator: main below trip level |
| main_gt_trip_hi | input | 1 | Comparator: main above trip level plus hysteresis |
| lp_mode | input | 1 | Low-power mode: trip comparison ignored |
| reseal_req | input | 1 | Request to return to the sealed condition |
| pwr_fail_clr | input | 1 | Clears the total-power-loss flag |
| sel_backup | output | 1 | Supply switch select, 1 = backup |
| bus_disable | output | 1 | Backup-mode flag that shuts off the serial bus |
| bat_connect | output | 1 | Battery connect enable |
| pwr_fail | output | 1 | Total-power-loss flag |
| trip_mon_en | output | 1 | Trip-level monitor enable |

## Verification
The bench builds the block with SYNC_STAGES=2 and DWELL=4. A transition therefore lands on the sixth rising edge after the input changes, and the bench checks that exact edge and the one before it. With a four-clock dwell, a three-clock glitch that must be rejected can be applied and recovered from within a few clocks. The same settings keep the full sequence short: seal, release, single-flag and dual-flag drops, both recovery paths, low-power mode and the reseal round trip all run in one short directed sequence.

// File: rtl/supsw_pkg.sv
package supsw_pkg;

    // Controller states; see the brief for the transition names.
    typedef enum logic [1:0] {
        ST_SEALED = 2'd0,
        ST_MAIN   = 2'd1,
        ST_BACKUP = 2'd2,
        ST_ARMED  = 2'd3
    } sw_state_t;

    // Comparator flag bundle, one bit per analog comparator.
    typedef struct packed {
        logic lt_bkp;   // main below backup minus hysteresis
        logic gt_bkp;   // main above backup plus hysteresis
        logic lt_trip;  // main below trip level
        logic gt_trip;  // main above trip level plus hysteresis
    } cmp_t;

    localparam int CMP_W = $bits(cmp_t);

endpackage

// File: rtl/supsw_sync.sv
module supsw_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    // Flop chain; each stage resets to "no condition".
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/supsw_cond.sv
module supsw_cond
    import supsw_pkg::*;
(
    input  cmp_t      cmp,
    input  logic      lp_mode,
    input  sw_state_t state,
    output logic      loss,
    output logic      good,
    output logic      qual
);

    // Trip comparators are dropped entirely in low-power mode.
    logic trip_low;
    logic trip_high;

    always_comb begin
        trip_low  = lp_mode ? 1'b1 : cmp.lt_trip;
        trip_high = lp_mode ? 1'b0 : cmp.gt_trip;
        // Loss needs both comparisons, recovery needs either.
        loss = cmp.lt_bkp & trip_low;
        good = cmp.gt_bkp | trip_high;
    end

    // Pick the condition the current state is waiting on.
    always_comb begin
        unique case (state)
            ST_SEALED: qual = good;
            ST_MAIN:   qual = loss;
            ST_BACKUP: qual = good;
            ST_ARMED:  qual = loss;
            default:   qual = 1'b0;
        endcase
    end

endmodule

// File: rtl/supsw_dwell.sv
module supsw_dwell #(
    parameter int DWELL = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic clear,
    output logic fire
);

    localparam int CW = (DWELL < 2) ? 1 : $clog2(DWELL);
    localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

    logic [CW-1:0] cnt;

    // Fire on the DWELL-th consecutive cycle with the condition true.
    assign fire = cond && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || !cond || fire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/supply_switch_ctrl.sv
module supply_switch_ctrl
    import supsw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DWELL       = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_lt_bkp_lo,
    input  logic main_gt_bkp_hi,
    input  logic main_lt_trip,
    input  logic main_gt_trip_hi,
    input  logic lp_mode,
    input  logic reseal_req,
    input  logic pwr_fail_clr,
    output logic sel_backup,
    output logic bus_disable,
    output logic bat_connect,
    output logic pwr_fail,
    output logic trip_mon_en
);

    cmp_t        cmp_raw;
    cmp_t        cmp_s;
    logic [CMP_W-1:0] cmp_q;
    sw_state_t   state;
    sw_state_t   state_nxt;
    logic        loss;
    logic        good;
    logic        qual;
    logic        fire;
    logic        st_change;
    logic        fail_q;

    always_comb begin
        cmp_raw.lt_bkp  = main_lt_bkp_lo;
        cmp_raw.gt_bkp  = main_gt_bkp_hi;
        cmp_raw.lt_trip = main_lt_trip;
        cmp_raw.gt_trip = main_gt_trip_hi;
    end

    supsw_sync #(
        .WIDTH  (CMP_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_raw),
        .q     (cmp_q)
    );

    assign cmp_s = cmp_t'(cmp_q);

    supsw_cond u_cond (
        .cmp     (cmp_s),
        .lp_mode (lp_mode),
        .state   (state),
        .loss    (loss),
        .good    (good),
        .qual    (qual)
    );

    supsw_dwell #(
        .DWELL (DWELL)
    ) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (qual),
        .clear (st_change),
        .fire  (fire)
    );

    // Next-state decision; reseal outranks a qualified drop.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SEALED: if (fire) state_nxt = ST_MAIN;
            ST_MAIN: begin
                if (reseal_req)  state_nxt = ST_ARMED;
                else if (fire)   state_nxt = ST_BACKUP;
            end
            ST_BACKUP: if (fire) state_nxt = ST_MAIN;
            ST_ARMED:  if (fire) state_nxt = ST_SEALED;
            default:   state_nxt = ST_SEALED;
        endcase
    end

    assign st_change = (state_nxt != state);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SEALED;
        else        state <= state_nxt;
    end

    // Output decode.
    always_comb begin
        sel_backup  = 1'b0;
        bus_disable = 1'b0;
        bat_connect = 1'b0;
        unique case (state)
            ST_SEALED: bat_connect = 1'b0;
            ST_MAIN:   bat_connect = 1'b1;
            ST_BACKUP: begin
                sel_backup  = 1'b1;
                bus_disable = 1'b1;
                bat_connect = 1'b1;
            end
            ST_ARMED:  bat_connect = 1'b0;
            default:   bat_connect = 1'b0;
        endcase
        trip_mon_en = ~lp_mode;
    end

    // Total-loss flag: set by reset only, cleared by request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            fail_q <= 1'b1;
        else if (pwr_fail_clr) fail_q <= 1'b0;
    end

    assign pwr_fail = fail_q;

endmodule

// File: rtl/supsw_chk.sv
module supsw_chk
    import supsw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      lp_mode,
    input logic      reseal_req,
    input logic      sel_backup,
    input logic      bus_disable,
    input logic      bat_connect,
    input logic      pwr_fail,
    input cmp_t      cmp_s,
    input sw_state_t state
);

    AST_NO_SEALED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_backup) |-> $past(bat_connect)); // R2

    AST_DROP_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sel_backup) && !$past(lp_mode)) |-> $past(cmp_s.lt_bkp && cmp_s.lt_trip)); // R4

    AST_RECOVER_EITHER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_backup) |-> $past(cmp_s.gt_bkp || (cmp_s.gt_trip && !lp_mode))); // R5

    AST_LP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sel_backup) && $past(lp_mode)) |-> $past(cmp_s.lt_bkp)); // R7

    AST_BACKUP_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_backup |-> (bus_disable && bat_connect)); // R8

    AST_RESEAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MAIN && reseal_req) |=> !bat_connect); // R9

    AST_ARMED_NO_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |=> !sel_backup); // R10

    AST_FLAG_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_fail |=> !pwr_fail); // R11

endmodule

bind supply_switch_ctrl supsw_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lp_mode     (lp_mode),
    .reseal_req  (reseal_req),
    .sel_backup  (sel_backup),
    .bus_disable (bus_disable),
    .bat_connect (bat_connect),
    .pwr_fail    (pwr_fail),
    .cmp_s       (cmp_s),
    .state       (state)
);

// File: tb/sim_supply_switch_ctrl.sv
module sim_supply_switch_ctrl;

    localparam int CLK_P = 10;
    localparam int SYNC  = 2;
    localparam int DW    = 4;
    localparam int LAT   = SYNC + DW;

    logic clk = 1'b0;
    logic rst_n;
    logic lt_bkp, gt_bkp, lt_trip, gt_trip;
    logic lp_mode, reseal_req, pwr_fail_clr;
    logic sel_backup, bus_disable, bat_connect, pwr_fail, trip_mon_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    supply_switch_ctrl #(
        .SYNC_STAGES (SYNC),
        .DWELL       (DW)
    ) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .main_lt_bkp_lo  (lt_bkp),
        .main_gt_bkp_hi  (gt_bkp),
        .main_lt_trip    (lt_trip),
        .main_gt_trip_hi (gt_trip),
        .lp_mode         (lp_mode),
        .reseal_req      (reseal_req),
        .pwr_fail_clr    (pwr_fail_clr),
        .sel_backup      (sel_backup),
        .bus_disable     (bus_disable),
        .bat_connect     (bat_connect),
        .pwr_fail        (pwr_fail),
        .trip_mon_en     (trip_mon_en)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cmp(input logic a, input logic b, input logic c, input logic d);
        lt_bkp = a; gt_bkp = b; lt_trip = c; gt_trip = d;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    // R1: state after reset
    task automatic t_reset();
        do_reset();
        chk("R1", "sel_backup", sel_backup, 1'b0);
        chk("R1", "bus_disable", bus_disable, 1'b0);
        chk("R1", "bat_connect", bat_connect, 1'b0);
        chk("R1", "pwr_fail", pwr_fail, 1'b1);
        chk("R1", "trip_mon_en", trip_mon_en, 1'b1);
    endtask

    // R2: sealed ignores a main loss
    task automatic t_sealed();
        set_cmp(1, 0, 1, 0);
        tick(20);
        chk("R2", "bat_connect sealed", bat_connect, 1'b0);
        chk("R2", "sel_backup sealed", sel_backup, 1'b0);
    endtask

    // R3/R6: seal release with exact latency
    task automatic t_release();
        set_cmp(0, 1, 0, 1);
        tick(LAT - 1);
        chk("R6", "bat_connect one edge early", bat_connect, 1'b0);
        tick(1);
        chk("R3", "bat_connect after release", bat_connect, 1'b1);
        chk("R3", "bus_disable in main", bus_disable, 1'b0);
    endtask

    // R4: a single low flag is not enough
    task automatic t_single_flag();
        set_cmp(1, 0, 0, 1);
        tick(20);
        chk("R4", "only below-backup", sel_backup, 1'b0);
        set_cmp(0, 1, 1, 0);
        tick(20);
        chk("R4", "only below-trip", sel_backup, 1'b0);
        set_cmp(0, 1, 0, 1);
        tick(4);
    endtask

    // R6: glitch shorter than the dwell
    task automatic t_glitch();
        set_cmp(1, 0, 1, 0);
        tick(DW - 1);
        set_cmp(0, 1, 0, 1);
        tick(10);
        chk("R6", "short loss rejected", sel_backup, 1'b0);
    endtask

    // R4/R8: drop with both flags
    task automatic t_drop();
        set_cmp(1, 0, 1, 0);
        tick(LAT - 1);
        chk("R6", "drop one edge early", sel_backup, 1'b0);
        tick(1);
        chk("R4", "sel_backup after drop", sel_backup, 1'b1);
        chk("R8", "bus_disable in backup", bus_disable, 1'b1);
        chk("R8", "bat_connect in backup", bat_connect, 1'b1);
    endtask

    // R5: each recovery flag alone
    task automatic t_recover();
        set_cmp(1, 0, 0, 1);
        tick(LAT - 1);
        chk("R5", "trip recover early", sel_backup, 1'b1);
        tick(1);
        chk("R5", "recover via trip", sel_backup, 1'b0);
        chk("R8", "bus_disable in main", bus_disable, 1'b0);
        set_cmp(1, 0, 1, 0);
        tick(LAT + 2);
        chk("R4", "re-drop", sel_backup, 1'b1);
        set_cmp(0, 1, 1, 0);
        tick(LAT);
        chk("R5", "recover via backup compare", sel_backup, 1'b0);
    endtask

    // R7: low-power mode
    task automatic t_lowpower();
        lp_mode = 1'b1;
        set_cmp(0, 1, 0, 1);
        tick(4);
        chk("R7", "trip_mon_en off", trip_mon_en, 1'b0);
        set_cmp(1, 0, 0, 1);
        tick(LAT - 1);
        chk("R7", "lp drop early", sel_backup, 1'b0);
        tick(1);
        chk("R7", "lp drop on backup compare only", sel_backup, 1'b1);
        tick(20);
        chk("R7", "trip-high ignored in lp", sel_backup, 1'b1);
        set_cmp(0, 1, 0, 1);
        tick(LAT);
        chk("R7", "lp recover", sel_backup, 1'b0);
        lp_mode = 1'b0;
        tick(2);
        chk("R1", "trip_mon_en back on", trip_mon_en, 1'b1);
    endtask

    // R9/R10: reseal round trip
    task automatic t_reseal();
        set_cmp(1, 0, 1, 0);
        tick(LAT + 2);
        reseal_req = 1'b1;
        tick(1);
        reseal_req = 1'b0;
        chk("R9", "reseal ignored in backup", sel_backup, 1'b1);
        set_cmp(0, 1, 0, 1);
        tick(LAT + 2);
        chk("R9", "main before reseal", bat_connect, 1'b1);
        reseal_req = 1'b1;
        tick(1);
        reseal_req = 1'b0;
        chk("R9", "battery off after reseal", bat_connect, 1'b0);
        tick(20);
        chk("R10", "armed holds battery off", bat_connect, 1'b0);
        set_cmp(1, 0, 1, 0);
        tick(20);
        chk("R10", "armed loss no backup", sel_backup, 1'b0);
        chk("R10", "armed loss battery off", bat_connect, 1'b0);
        set_cmp(0, 1, 0, 1);
        tick(LAT - 1);
        chk("R10", "reseal release early", bat_connect, 1'b0);
        tick(1);
        chk("R10", "release after reseal", bat_connect, 1'b1);
    endtask

    // R11: power-fail flag
    task automatic t_flag();
        chk("R11", "flag still set", pwr_fail, 1'b1);
        pwr_fail_clr = 1'b1;
        tick(1);
        pwr_fail_clr = 1'b0;
        chk("R11", "flag cleared", pwr_fail, 1'b0);
        tick(10);
        chk("R11", "flag stays low", pwr_fail, 1'b0);
        do_reset();
        chk("R11", "flag set by reset", pwr_fail, 1'b1);
    endtask

    initial begin
        rst_n        = 1'b0;
        lp_mode      = 1'b0;
        reseal_req   = 1'b0;
        pwr_fail_clr = 1'b0;
        set_cmp(0, 0, 0, 0);
        t_reset();
        t_sealed();
        t_release();
        t_single_flag();
        t_glitch();
        t_drop();
        t_recover();
        t_lowpower();
        t_reseal();
        t_flag();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule